// File: doc/BRIEF.md
# Masked Pin-Pattern Edge Event Detector

This block watches one of two 32-bit input ports for a pattern. A single-cycle configure strobe captures four settings: which port to watch, whether the test is for equality or for inequality, a bit mask, and a match value. From the next clock on, the block ANDs the selected port with the stored mask and compares the result with the stored match value. The equality or inequality outcome is the block's condition. A sticky event flag is raised only on the cycle in which the condition changes from false to true. A pattern that is already present at configure time therefore produces no event until it goes away and then comes back.

The flag can be consumed in two ways. A poll strobe reads the flag on the `poll_flag` output and clears it without stalling, so the requester can keep doing other work. A wait strobe starts a stall. `wait_busy` stays high until the flag is set. The flag is then consumed and `wait_done` pulses for one cycle. The reset is asynchronous and active low, and the surrounding reset tree must release it synchronously to `clk`.

Top module: `pin_pattern_event`

## Requirements
- R1: After reset `poll_flag`, `wait_busy` and `wait_done` are 0. The reset settings (mask 0, match 0, port A, inequality) give a false condition, so no event occurs before the first configuration, whatever the ports do.
- R2: When `cfg_port_b` is 1 at the configure strobe, only `port_b` is compared. When it is 0, only `port_a` is compared. Changes on the other port have no effect.
- R3: The condition is ((selected port AND mask) == match) when `cfg_eq` is 1, and its inverse when `cfg_eq` is 0. The match value is not masked, so a match bit set outside the mask keeps an equality test from ever becoming true.
- R4: When the condition goes from false to true, `poll_flag` is 1 after that clock edge. While the condition stays true, no further event is raised.
- R5: When the condition is already true at the configure strobe, no event is raised until it has gone false and then true again.
- R6: A configure strobe clears a pending flag at the same edge.
- R7: `poll_flag` shows the current flag. A cycle with `poll_req` high clears the flag at that edge.
- R8: When a rising transition and a poll fall on the same edge, the flag stays set.
- R9: A wait started while the flag is clear raises `wait_busy` from the next cycle. It holds `wait_busy` until the flag has been seen set. At the edge after that, the flag clears, `wait_busy` falls and `wait_done` is 1 for exactly one cycle.
- R10: A wait started while the flag is already set gives `wait_done` on the next cycle. `wait_busy` is never raised, and the flag is cleared.
- R11: Once set, the flag stays set after the condition goes false, until a poll, a wait or a configure strobe consumes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_a | input | 32 | First watched port |
| port_b | input | 32 | Second watched port |
| cfg_valid | input | 1 | Configure strobe |
| cfg_port_b | input | 1 | 1 watches port_b, 0 watches port_a |
| cfg_eq | input | 1 | 1 tests equality, 0 tests inequality |
| cfg_mask | input | 32 | Mask applied to the watched port |
| cfg_match | input | 32 | Value compared with the masked port |
| poll_req | input | 1 | Poll strobe; clears the flag |
| poll_flag | output | 1 | Current event flag |
| wait_start | input | 1 | Starts a stalling wait |
| wait_busy | output | 1 | Wait pending, flag not yet seen |
| wait_done | output | 1 | One-cycle pulse when a wait completes |

## Verification
The assertions check the flag update rules on every cycle: a configure strobe clears the flag, a false-to-true step sets it, and nothing else sets it. They also check that a poll clears the flag but loses to a simultaneous rise, and that a wait completes only on a set flag. The way the condition is formed is shown only by the bench's scenarios. These cover port selection, the equal and not-equal senses, the unmasked match value, and a pattern already present at configuration. The bench scenarios also cover the exact cycle timing of a stalled wait and of a wait that finds the flag already set.

// File: rtl/ppe_pkg.sv
package ppe_pkg;
  typedef enum logic { PORT_A = 1'b0, PORT_B = 1'b1 } port_sel_e;
  typedef enum logic { TEST_NE = 1'b0, TEST_EQ = 1'b1 } test_sense_e;
endpackage

// File: rtl/ppe_cfg_reg.sv
module ppe_cfg_reg
  import ppe_pkg::*;
#(
  parameter int W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_valid,
  input  logic        cfg_port_b,
  input  logic        cfg_eq,
  input  logic [W-1:0] cfg_mask,
  input  logic [W-1:0] cfg_match,
  output port_sel_e   sel_q,
  output test_sense_e sense_q,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] match_q
);
  port_sel_e   sel_d;
  test_sense_e sense_d;
  logic [W-1:0] mask_d;
  logic [W-1:0] match_d;

  always_comb begin
    sel_d   = sel_q;
    sense_d = sense_q;
    mask_d  = mask_q;
    match_d = match_q;
    if (cfg_valid) begin
      sel_d   = port_sel_e'(cfg_port_b);
      sense_d = test_sense_e'(cfg_eq);
      mask_d  = cfg_mask;
      match_d = cfg_match;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= PORT_A;
      sense_q <= TEST_NE;
      mask_q  <= '0;
      match_q <= '0;
    end else begin
      sel_q   <= sel_d;
      sense_q <= sense_d;
      mask_q  <= mask_d;
      match_q <= match_d;
    end
  end
endmodule

// File: rtl/ppe_compare.sv
module ppe_compare
  import ppe_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] port_a,
  input  logic [W-1:0] port_b,
  input  port_sel_e    sel,
  input  test_sense_e  sense,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] match,
  output logic         cond
);
  logic [W-1:0] picked;
  logic         same;

  always_comb begin
    picked = (sel == PORT_B) ? port_b : port_a;
    same   = ((picked & mask) == match);
    cond   = (sense == TEST_EQ) ? same : !same;
  end
endmodule

// File: rtl/ppe_event.sv
module ppe_event (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_valid,
  input  logic cond_live,
  input  logic cond_load,
  input  logic poll_req,
  input  logic wait_start,
  output logic flag_q,
  output logic busy_q,
  output logic done_q
);
  logic prev_q, prev_d;
  logic flag_d, busy_d, done_d;
  logic rise, waiting, hit, consume;

  always_comb begin
    rise    = cond_live && !prev_q && !cfg_valid;
    waiting = wait_start || busy_q;
    hit     = waiting && flag_q;
    consume = poll_req || hit;
    prev_d  = cfg_valid ? cond_load : cond_live;
    flag_d  = cfg_valid ? 1'b0 : (rise || (flag_q && !consume));
    busy_d  = waiting && !flag_q;
    done_d  = hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      flag_q <= flag_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assert_cfg_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |=> !flag_q);
  assert_rise_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_live && !prev_q && !cfg_valid) |=> flag_q);
  assert_no_spurious_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && !(cond_live && !prev_q)) |=> !flag_q);
  assert_poll_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_req && !(cond_live && !prev_q)) |=> !flag_q);
  assert_rise_beats_poll_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_req && cond_live && !prev_q && !cfg_valid) |=> flag_q);
  assert_wait_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && flag_q) |=> (done_q && !busy_q));
  assert_done_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(flag_q));
endmodule

// File: rtl/pin_pattern_event.sv
module pin_pattern_event
  import ppe_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] port_a,
  input  logic [W-1:0] port_b,
  input  logic         cfg_valid,
  input  logic         cfg_port_b,
  input  logic         cfg_eq,
  input  logic [W-1:0] cfg_mask,
  input  logic [W-1:0] cfg_match,
  input  logic         poll_req,
  output logic         poll_flag,
  input  logic         wait_start,
  output logic         wait_busy,
  output logic         wait_done
);
  port_sel_e    sel_q;
  test_sense_e  sense_q;
  logic [W-1:0] mask_q, match_q;
  logic         cond_live, cond_load;

  ppe_cfg_reg #(.W(W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid),
    .cfg_port_b(cfg_port_b), .cfg_eq(cfg_eq),
    .cfg_mask(cfg_mask), .cfg_match(cfg_match),
    .sel_q(sel_q), .sense_q(sense_q), .mask_q(mask_q), .match_q(match_q)
  );

  // live test with the stored settings
  ppe_compare #(.W(W)) u_cmp_live (
    .port_a(port_a), .port_b(port_b), .sel(sel_q), .sense(sense_q),
    .mask(mask_q), .match(match_q), .cond(cond_live)
  );

  // test with the incoming settings, seeds the previous-condition state
  ppe_compare #(.W(W)) u_cmp_load (
    .port_a(port_a), .port_b(port_b),
    .sel(port_sel_e'(cfg_port_b)), .sense(test_sense_e'(cfg_eq)),
    .mask(cfg_mask), .match(cfg_match), .cond(cond_load)
  );

  ppe_event u_evt (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid),
    .cond_live(cond_live), .cond_load(cond_load),
    .poll_req(poll_req), .wait_start(wait_start),
    .flag_q(poll_flag), .busy_q(wait_busy), .done_q(wait_done)
  );
endmodule

// File: tb/pin_pattern_event_test.sv
module pin_pattern_event_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] port_a = '0, port_b = '0, cfg_mask = '0, cfg_match = '0;
  logic        cfg_valid = 1'b0, cfg_port_b = 1'b0, cfg_eq = 1'b0;
  logic        poll_req = 1'b0, wait_start = 1'b0;
  logic        poll_flag, wait_busy, wait_done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    logic  flag;
    logic  busy;
    logic  done;
    string tag;
  } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  pin_pattern_event uut (
    .clk(clk), .rst_n(rst_n), .port_a(port_a), .port_b(port_b),
    .cfg_valid(cfg_valid), .cfg_port_b(cfg_port_b), .cfg_eq(cfg_eq),
    .cfg_mask(cfg_mask), .cfg_match(cfg_match), .poll_req(poll_req),
    .poll_flag(poll_flag), .wait_start(wait_start),
    .wait_busy(wait_busy), .wait_done(wait_done)
  );

  // monitor: compares outputs with the oldest expectation
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (poll_flag !== e.flag || wait_busy !== e.busy || wait_done !== e.done) begin
        errors++;
        $display("FAIL %s: got flag=%b busy=%b done=%b expected flag=%b busy=%b done=%b",
                 e.tag, poll_flag, wait_busy, wait_done, e.flag, e.busy, e.done);
      end
    end
  end

  // driver: one clock with the current inputs, then the expected outputs
  task automatic cyc(input logic f, input logic b, input logic d, input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    e.flag = f; e.busy = b; e.done = d; e.tag = tag;
    q.push_back(e);
    cfg_valid  = 1'b0;
    poll_req   = 1'b0;
    wait_start = 1'b0;
    @(negedge clk);
    #1;
  endtask

  task automatic configure(input logic pb, input logic eq,
                           input logic [31:0] m, input logic [31:0] v);
    cfg_valid = 1'b1; cfg_port_b = pb; cfg_eq = eq; cfg_mask = m; cfg_match = v;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (poll_flag !== 1'b0 || wait_busy !== 1'b0 || wait_done !== 1'b0) begin
      errors++;
      $display("FAIL R1: got %b%b%b expected 000", poll_flag, wait_busy, wait_done);
    end
    rst_n = 1'b1;
    #1;
    // R1: no event before configuration
    port_a = 32'h0000_0001; cyc(0, 0, 0, "R1");
    port_a = 32'hFFFF_FFFF; port_b = 32'h1234_5678; cyc(0, 0, 0, "R1");
    port_a = 32'h0; port_b = 32'h0; cyc(0, 0, 0, "R1");

    // R2/R3/R4/R11 on port A, equality
    configure(0, 1, 32'h0000_00F0, 32'h0000_0050); cyc(0, 0, 0, "R3");
    port_a = 32'h1234_5657; cyc(1, 0, 0, "R4");
    port_b = 32'hDEAD_BEEF; cyc(1, 0, 0, "R11");
    port_a = 32'h0; cyc(1, 0, 0, "R11");
    poll_req = 1'b1; cyc(0, 0, 0, "R7");
    port_a = 32'hFFFF_FF5F; cyc(1, 0, 0, "R4");
    poll_req = 1'b1; cyc(0, 0, 0, "R7");
    cyc(0, 0, 0, "R4");

    // R2: port B selected, port A ignored
    port_b = 32'h0;
    configure(1, 1, 32'hFF00_0000, 32'hA500_0000); cyc(0, 0, 0, "R2");
    port_a = 32'hA500_0000; cyc(0, 0, 0, "R2");
    port_b = 32'hA5FF_FFFF; cyc(1, 0, 0, "R2");
    // R6 and R5: reconfigure while pattern present
    configure(1, 1, 32'hFF00_0000, 32'hA500_0000); cyc(0, 0, 0, "R6");
    cyc(0, 0, 0, "R5");
    port_b = 32'h0; cyc(0, 0, 0, "R5");
    port_b = 32'hA500_0001; cyc(1, 0, 0, "R5");
    poll_req = 1'b1; cyc(0, 0, 0, "R7");

    // R3: inequality
    port_a = 32'h3;
    configure(0, 0, 32'h0000_000F, 32'h0000_0003); cyc(0, 0, 0, "R3");
    port_a = 32'h7; cyc(1, 0, 0, "R3");
    poll_req = 1'b1; cyc(0, 0, 0, "R7");

    // R3: match bit outside mask blocks equality
    port_a = 32'h13;
    configure(0, 1, 32'h0000_000F, 32'h0000_0013); cyc(0, 0, 0, "R3");
    port_a = 32'hFFFF_FFF3; cyc(0, 0, 0, "R3");
    port_a = 32'h0; cyc(0, 0, 0, "R3");
    port_a = 32'h13; cyc(0, 0, 0, "R3");

    // R8: rise and poll on the same edge
    port_a = 32'h0;
    configure(0, 1, 32'h1, 32'h1); cyc(0, 0, 0, "R8");
    port_a = 32'h1; cyc(1, 0, 0, "R8");
    port_a = 32'h0; cyc(1, 0, 0, "R11");
    port_a = 32'h1; poll_req = 1'b1; cyc(1, 0, 0, "R8");
    poll_req = 1'b1; cyc(0, 0, 0, "R7");

    // R9: wait stalls until the event
    port_a = 32'h0; cyc(0, 0, 0, "R9");
    wait_start = 1'b1; cyc(0, 1, 0, "R9");
    cyc(0, 1, 0, "R9");
    port_a = 32'h1; cyc(1, 1, 0, "R9");
    cyc(0, 0, 1, "R9");
    cyc(0, 0, 0, "R9");

    // R10: wait with the flag already set
    port_a = 32'h0; cyc(0, 0, 0, "R10");
    port_a = 32'h1; cyc(1, 0, 0, "R10");
    wait_start = 1'b1; cyc(0, 0, 1, "R10");
    cyc(0, 0, 0, "R10");

    @(negedge clk);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule